// File: doc/BRIEF.md
# Escaped word-stream frame extractor

This block sits behind a CPU extraction queue that delivers 32-bit words one at a time. Each frame in the stream starts with a fixed-length internal header. After the header come frame words in which a small set of reserved 32-bit values act as in-band controls. These controls mark the end of the frame, give the number of unused bytes in the last word, prune or abort the frame, escape the next word, or mark a gap where no data is present. The block removes the header, picks the source port number out of it, decodes the controls, and emits the frame bytes without the trailing 4-byte FCS as a stream of beats with a byte-keep mask and a last flag.

An end code only arrives after the final data word. The FCS can also straddle the last two words. For these reasons the block holds back the two most recent data words and releases a word only once it is known not to belong to the FCS. Every frame closes with a one-cycle status pulse that reports accept or discard together with the source port. A downstream consumer that sees a discard drops whatever beats it has already collected for that frame.

The state machine has four states. HDR counts header words. BODY decodes controls and data. LIT takes the word after an escape. TAIL takes the word after a prune. The transitions are:
- HDR to BODY on the last header word.
- BODY to HDR on an end or abort code.
- BODY to LIT on an escape code.
- BODY to TAIL on a prune code.
- LIT to BODY on any word.
- TAIL to HDR on any word.

Top module: `escword_frame_unpack`

## Requirements
- R1: While reset is asserted and right after it is released, in_ready is 1, m_tvalid is 0 and st_valid is 0, and the block expects a header.
- R2: The first 9 words of every frame are header. They are never decoded as controls and never forwarded. Within the header, byte k lies in word k/4, and the first byte of a word is bits 31:24. Header bytes 27..30 are joined with byte 27 most significant. The result is shifted right by 5, and bits 7:1 of the shifted value become st_port. For the default sizes, st_port equals bits 20:14 of header word 7.
- R3: Every data word is forwarded unmodified as one beat, in arrival order. Every beat except the last has m_tkeep = 4'b1111 and m_tlast = 0.
- R4: A word 0x80000000+u, with u in 0..3, ends the frame, where u is the number of unused bytes in the final word. If at least two data words were received, the frame is accepted. The final word is then dropped, and the word before it is the last beat, with m_tlast = 1 and m_tkeep selecting the low 4-u lanes (u=0: 1111, u=1: 0111, u=2: 0011, u=3: 0001).
- R5: The word 0x80000007 is skipped. It adds no data and leaves the frame open.
- R6: After 0x80000006, the next word is data whatever its value.
- R7: After 0x80000004, exactly one more word is consumed without decoding and the frame ends as a discard.
- R8: The word 0x80000005 ends the frame at once as a discard.
- R9: With cfg_swap = 1, a word is byte-reversed before it is compared with the control values, while data is forwarded as received.
- R10: An end code that follows fewer than two data words ends the frame as a discard and produces no beat.
- R11: While m_tvalid = 1 and m_tready = 0, the beat holds stable and in_ready is 0.
- R12: Each frame produces exactly one single-cycle st_valid pulse. On a discarded frame that produced beats, the last beat carries m_tlast with m_tkeep = 4'b1111. An accepted frame's status appears in the same cycle as its final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_swap | input | 1 | Byte-reverse words before control comparison |
| in_word | input | 32 | Word from the extraction queue |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Block accepts in_word this cycle |
| m_tdata | output | 32 | Frame bytes, lane i in bits 8i+7:8i |
| m_tkeep | output | 4 | Valid byte lanes |
| m_tlast | output | 1 | Final beat of the frame |
| m_tvalid | output | 1 | Beat is valid |
| m_tready | input | 1 | Downstream accepts the beat |
| st_valid | output | 1 | Frame status pulse |
| st_accept | output | 1 | 1 = frame accepted, 0 = discard |
| st_port | output | 7 | Source port from the header |

## Verification
The word that ends a frame does two jobs in one clock cycle. It releases the held-back word as the final beat, with its keep mask trimmed by the FCS, and it raises the status pulse. Every table frame provokes this coincidence, and a monitor compares the final beat's lanes and flag against the status outcome. A second collision is built from an escape that is directly followed by a value equal to an end code, and from a pruned tail word that is itself an end code. In both cases the framing must not close early, and the next frame's header must still be counted from its first word.

// File: rtl/ewx_pkg.sv
package ewx_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam logic [WORD_W-1:0] CODE_BASE = 32'h8000_0000;

    typedef enum logic [2:0] {
        K_DATA,
        K_END,
        K_PRUNE,
        K_ABORT,
        K_ESC,
        K_IDLE
    } kind_e;

    typedef enum logic [1:0] {
        S_HDR,
        S_BODY,
        S_LIT,
        S_TAIL
    } state_e;

    function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [LANES-1:0] keep_of(input logic [1:0] unused);
        logic [LANES-1:0] k;
        unique case (unused)
            2'd0: k = 4'b1111;
            2'd1: k = 4'b0111;
            2'd2: k = 4'b0011;
            2'd3: k = 4'b0001;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ewx_classify.sv
module ewx_classify
    import ewx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              swap,
    output kind_e             kind,
    output logic [1:0]        unused
);

    logic [WORD_W-1:0] cmp;

    assign cmp    = swap ? bswap32(word) : word;
    assign unused = cmp[1:0];

    always_comb begin
        if (cmp[WORD_W-1:3] == CODE_BASE[WORD_W-1:3]) begin
            unique case (cmp[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: kind = K_END;
                3'd4:                   kind = K_PRUNE;
                3'd5:                   kind = K_ABORT;
                3'd6:                   kind = K_ESC;
                3'd7:                   kind = K_IDLE;
            endcase
        end else begin
            kind = K_DATA;
        end
    end

endmodule

// File: rtl/ewx_port_pick.sv
module ewx_port_pick #(
    parameter int HDR_WORDS  = 9,
    parameter int FIELD_BYTE = 27,
    parameter int BIT_POS    = 6,
    parameter int PORT_W     = 7,
    localparam int IDX_W     = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_fire,
    input  logic [IDX_W-1:0]  hdr_idx,
    input  logic [31:0]       hdr_word,
    output logic [PORT_W-1:0] port
);

    logic [31:0] field_q;
    logic [31:0] field_d;

    always_comb begin
        field_d = field_q;
        for (int b = 0; b < 4; b++) begin
            for (int f = 0; f < 4; f++) begin
                if (int'(hdr_idx) * 4 + b == FIELD_BYTE + f)
                    field_d[31-8*f -: 8] = hdr_word[31-8*b -: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            field_q <= '0;
        else if (hdr_fire)
            field_q <= field_d;
    end

    assign port = field_q[BIT_POS +: PORT_W];

endmodule

// File: rtl/escword_frame_unpack.sv
module escword_frame_unpack
    import ewx_pkg::*;
#(
    parameter int HDR_WORDS       = 9,
    parameter int PORT_FIELD_BYTE = 27,
    parameter int PORT_RSHIFT     = 5,
    parameter int PORT_SEL_LSB    = 1,
    parameter int PORT_W          = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_swap,
    input  logic [31:0]       in_word,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [31:0]       m_tdata,
    output logic [3:0]        m_tkeep,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              st_valid,
    output logic              st_accept,
    output logic [PORT_W-1:0] st_port
);

    localparam int IDX_W   = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam int BIT_POS = PORT_RSHIFT + PORT_SEL_LSB;
    localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(HDR_WORDS - 1);
    localparam logic [1:0]       HOLD_FULL = 2'd2;

    state_e            state_q, state_d;
    logic [IDX_W-1:0]  hdr_idx_q;
    logic [WORD_W-1:0] hold_old_q, hold_new_q;
    logic [1:0]        hold_cnt_q;
    kind_e             kind;
    logic [1:0]        unused;
    logic [PORT_W-1:0] port;
    logic              fire, push, finish, good;

    assign in_ready = !m_tvalid || m_tready;
    assign fire     = in_valid && in_ready;

    ewx_classify u_classify (
        .word   (in_word),
        .swap   (cfg_swap),
        .kind   (kind),
        .unused (unused)
    );

    ewx_port_pick #(
        .HDR_WORDS  (HDR_WORDS),
        .FIELD_BYTE (PORT_FIELD_BYTE),
        .BIT_POS    (BIT_POS),
        .PORT_W     (PORT_W)
    ) u_port_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdr_fire (fire && state_q == S_HDR),
        .hdr_idx  (hdr_idx_q),
        .hdr_word (in_word),
        .port     (port)
    );

    // Transition process
    always_comb begin
        state_d = state_q;
        if (fire) begin
            unique case (state_q)
                S_HDR:  if (hdr_idx_q == HDR_LAST) state_d = S_BODY;
                S_BODY: begin
                    case (kind)
                        K_END, K_ABORT: state_d = S_HDR;
                        K_ESC:          state_d = S_LIT;
                        K_PRUNE:        state_d = S_TAIL;
                        default:        state_d = S_BODY;
                    endcase
                end
                S_LIT:  state_d = S_BODY;
                S_TAIL: state_d = S_HDR;
            endcase
        end
    end

    // Action decode
    always_comb begin
        push   = 1'b0;
        finish = 1'b0;
        good   = 1'b0;
        if (fire) begin
            unique case (state_q)
                S_HDR:  ;
                S_BODY: begin
                    case (kind)
                        K_DATA:  push = 1'b1;
                        K_END:   begin
                            finish = 1'b1;
                            good   = (hold_cnt_q == HOLD_FULL);
                        end
                        K_ABORT: finish = 1'b1;
                        default: ;
                    endcase
                end
                S_LIT:  push   = 1'b1;
                S_TAIL: finish = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_HDR;
            hdr_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (fire && state_q == S_HDR)
                hdr_idx_q <= (hdr_idx_q == HDR_LAST) ? '0 : hdr_idx_q + 1'b1;
        end
    end

    // Two-word hold-back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_old_q <= '0;
            hold_new_q <= '0;
            hold_cnt_q <= '0;
        end else if (push) begin
            hold_old_q <= hold_new_q;
            hold_new_q <= in_word;
            hold_cnt_q <= (hold_cnt_q == HOLD_FULL) ? HOLD_FULL : hold_cnt_q + 1'b1;
        end else if (finish) begin
            hold_cnt_q <= '0;
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tvalid  <= 1'b0;
            m_tdata   <= '0;
            m_tkeep   <= '0;
            m_tlast   <= 1'b0;
            st_valid  <= 1'b0;
            st_accept <= 1'b0;
            st_port   <= '0;
        end else begin
            if ((push || finish) && hold_cnt_q == HOLD_FULL) begin
                m_tvalid <= 1'b1;
                m_tdata  <= hold_old_q;
                m_tkeep  <= good ? keep_of(unused) : 4'b1111;
                m_tlast  <= finish;
            end else if (m_tready) begin
                m_tvalid <= 1'b0;
            end
            st_valid  <= finish;
            st_accept <= finish && good;
            if (finish)
                st_port <= port;
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

    // R12
    accept_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_accept |-> m_tvalid && m_tlast);

    // R12
    status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);

    // R3
    mid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tlast |-> m_tkeep == 4'b1111);

    // R4
    keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> m_tkeep inside {4'b0001, 4'b0011, 4'b0111, 4'b1111});

    // R2
    status_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> state_q == S_HDR);

endmodule

// File: tb/test_escword_frame_unpack.sv
`timescale 1ns/1ps
module test_escword_frame_unpack;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_swap;
    logic [31:0] in_word;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep;
    logic        m_tlast;
    logic        m_tvalid;
    logic        m_tready;
    logic        st_valid;
    logic        st_accept;
    logic [6:0]  st_port;

    always #4 clk = ~clk;

    escword_frame_unpack i_escword_frame_unpack (
        .clk (clk), .rst_n (rst_n), .cfg_swap (cfg_swap),
        .in_word (in_word), .in_valid (in_valid), .in_ready (in_ready),
        .m_tdata (m_tdata), .m_tkeep (m_tkeep), .m_tlast (m_tlast),
        .m_tvalid (m_tvalid), .m_tready (m_tready),
        .st_valid (st_valid), .st_accept (st_accept), .st_port (st_port)
    );

    int checks = 0;
    int errors = 0;

    // Stimulus table: {swap, port, data words, unused bytes, ending 0=end 1=abort 2=prune}
    localparam logic [17:0] VEC [9] = '{
        {1'b0, 7'd5,   6'd4, 2'd0, 2'd0},
        {1'b0, 7'd127, 6'd5, 2'd1, 2'd0},
        {1'b1, 7'd0,   6'd3, 2'd2, 2'd0},
        {1'b1, 7'd64,  6'd6, 2'd3, 2'd0},
        {1'b0, 7'd33,  6'd4, 2'd0, 2'd1},
        {1'b1, 7'd90,  6'd3, 2'd0, 2'd2},
        {1'b0, 7'd12,  6'd1, 2'd0, 2'd0},
        {1'b0, 7'd77,  6'd2, 2'd3, 2'd0},
        {1'b0, 7'd9,   6'd0, 2'd0, 2'd1}
    };

    logic [31:0] g_data [64];
    logic [3:0]  g_keep [64];
    logic        g_last [64];
    int          g_n = 0;
    int          s_n = 0;
    logic        s_ok = 1'b0;
    logic [6:0]  s_port = '0;
    logic [31:0] exp_d [64];

    always @(negedge clk) begin
        if (m_tvalid && m_tready) begin
            if (g_n < 64) begin
                g_data[g_n] = m_tdata;
                g_keep[g_n] = m_tkeep;
                g_last[g_n] = m_tlast;
            end
            g_n++;
        end
        if (st_valid) begin
            s_n++;
            s_ok   = st_accept;
            s_port = st_port;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl(input logic [31:0] c);
        return cfg_swap ? {c[7:0], c[15:8], c[23:16], c[31:24]} : c;
    endfunction

    function automatic logic [3:0] keepx(input logic [1:0] u);
        return (u == 2'd0) ? 4'b1111 : (u == 2'd1) ? 4'b0111 : (u == 2'd2) ? 4'b0011 : 4'b0001;
    endfunction

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(posedge clk);
        #1;
        g_n = 0;
        s_n = 0;
    endtask

    // R2: header word 3 looks like an abort, word 7 carries the port in bits 20:14
    task automatic send_hdr(input logic [6:0] port);
        for (int i = 0; i < 9; i++)
            send(i == 3 ? 32'h8000_0005 : (i == 7 ? {11'h3C5, port, 14'h1A5A} : 32'h1111_0000 + 32'(i)));
    endtask

    task automatic judge(input string req, input int nb, input logic [3:0] lk, input logic ok, input logic [6:0] port);
        idle(4);
        chk(req, "beat count", 32'(g_n), 32'(nb));
        for (int i = 0; i < nb && i < 64; i++) begin
            chk("R3", "data", g_data[i], exp_d[i]);
            chk(req, "keep", {28'd0, g_keep[i]}, {28'd0, (i == nb - 1) ? lk : 4'b1111});
            chk(req, "last", {31'd0, g_last[i]}, {31'd0, i == nb - 1});
        end
        chk("R12", "status count", 32'(s_n), 32'd1);
        chk(req, "accept", {31'd0, s_ok}, {31'd0, ok});
        chk("R2", "port", {25'd0, s_port}, {25'd0, port});
        clear_mon();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [17:0] e;
        int          n;
        int          nb;
        logic        ok;
        string       req;

        rst_n = 1'b0; in_valid = 1'b0; in_word = '0; cfg_swap = 1'b0; m_tready = 1'b1;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", "in_ready in reset", {31'd0, in_ready}, 32'd1);
        chk("R1", "m_tvalid in reset", {31'd0, m_tvalid}, 32'd0);
        chk("R1", "st_valid in reset", {31'd0, st_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
        chk("R1", "m_tvalid after reset", {31'd0, m_tvalid}, 32'd0);

        // Table walk
        for (int v = 0; v < 9; v++) begin
            e = VEC[v];
            cfg_swap = e[17];
            n = int'(e[9:4]);
            send_hdr(e[16:10]);
            for (int i = 0; i < n; i++) begin
                exp_d[i] = 32'hA500_0000 | (32'(v) << 8) | 32'(i);
                send(exp_d[i]);
            end
            unique case (e[1:0])
                2'd0: send(ctrl(32'h8000_0000 | {30'd0, e[3:2]}));
                2'd1: send(ctrl(32'h8000_0005));
                default: begin
                    send(ctrl(32'h8000_0004));
                    send(ctrl(32'h8000_0000));
                end
            endcase
            nb = (n >= 2) ? n - 1 : 0;
            ok = (e[1:0] == 2'd0) && (n >= 2);
            if (e[1:0] == 2'd1)      req = "R8";
            else if (e[1:0] == 2'd2) req = "R7";
            else if (!ok)            req = "R10";
            else if (e[17])          req = "R9";
            else                     req = "R4";
            judge(req, nb, ok ? keepx(e[3:2]) : 4'b1111, ok, e[16:10]);
        end

        // R5 and R6: gap word and escaped end code inside a frame
        cfg_swap = 1'b0;
        send_hdr(7'd3);
        exp_d[0] = 32'h0102_0304; exp_d[1] = 32'h0506_0708; exp_d[2] = 32'h8000_0002; exp_d[3] = 32'h0A0B_0C0D;
        send(exp_d[0]);
        send(32'h8000_0007);
        send(exp_d[1]);
        send(32'h8000_0006);
        send(exp_d[2]);
        send(exp_d[3]);
        send(32'h8000_0000);
        judge("R6", 3, 4'b1111, 1'b1, 7'd3);

        // R5: only gap words before the end code gives a runt
        send_hdr(7'd44);
        send(32'h8000_0007);
        send(32'h8000_0007);
        send(32'h8000_0001);
        judge("R5", 0, 4'b1111, 1'b0, 7'd44);

        // R9: unswapped control values are data when swap is on
        cfg_swap = 1'b1;
        send_hdr(7'd100);
        exp_d[0] = 32'h8000_0007; exp_d[1] = 32'h8000_0005; exp_d[2] = 32'hA5A5_0001;
        send(exp_d[0]);
        send(exp_d[1]);
        send(exp_d[2]);
        send(ctrl(32'h8000_0002));
        judge("R9", 2, 4'b0011, 1'b1, 7'd100);

        // R11: back-pressure stalls the first beat and the input
        cfg_swap = 1'b0;
        @(posedge clk); #1 m_tready = 1'b0;
        for (int i = 0; i < 5; i++) exp_d[i] = 32'h3300_0000 + 32'(i);
        fork
            begin
                send_hdr(7'd55);
                for (int i = 0; i < 5; i++) send(exp_d[i]);
                send(32'h8000_0000);
            end
        join_none
        repeat (20) @(negedge clk);
        chk("R11", "in_ready while stalled", {31'd0, in_ready}, 32'd0);
        chk("R11", "m_tvalid while stalled", {31'd0, m_tvalid}, 32'd1);
        chk("R11", "m_tdata while stalled", m_tdata, exp_d[0]);
        chk("R11", "no handshake while stalled", 32'(g_n), 32'd0);
        @(posedge clk); #1 m_tready = 1'b1;
        wait fork;
        judge("R11", 4, 4'b1111, 1'b1, 7'd55);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule